// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer, modelled entirely in the digital domain on a single clock. A dual-modulus prescaler divides the input clock by either P or P+1. Two counters run on the prescaler's output ticks: a 6-bit swallow counter and a 13-bit main counter. For the first A prescaler periods of each output period the prescaler divides by P+1. It then divides by P for the remaining B−A periods. The total division ratio is therefore N = P*B + A.

The modulus pair is chosen with a 2-bit mode code. New mode, A and B values are presented on the inputs and accepted with a one-cycle load strobe. An accepted setting waits as pending until the period in progress ends, so no output period is ever cut short. A setting with B below 3 or with B below A is rejected. The reject raises an error flag, and the divider keeps its previous legal setting.

Top module: `pswallow_divider`

## Requirements
- R1: The mode code selects the prescaler base modulus P: code 0 gives 8 (8/9), code 1 gives 16 (16/17), code 2 gives 32 (32/33), code 3 gives 64 (64/65).
- R2: With an active setting (P, A, B), consecutive output pulses are exactly P*B + A input clock cycles apart.
- R3: The output pulse is high for exactly one clock cycle, the last cycle of each period.
- R4: A setting with B equal to A, or with B equal to 3, is legal: it is accepted without raising the error flag.
- R5: A load with B less than 3 raises the error flag in the cycle after the load, and the division ratio stays unchanged.
- R6: A load with B less than A raises the error flag in the cycle after the load, and any setting accepted earlier is kept.
- R7: An accepted load does not change the period in progress; the new ratio applies from the period that starts after the next output pulse.
- R8: The error flag stays set until the next legal load, which clears it in the cycle after that load.
- R9: A synchronous active-high reset clears the error flag and the output, and it installs the default setting (code 0, A = 0, B = 3). The first period after reset is therefore 24 cycles long.
- R10: Changes on the mode, A and B inputs while the load strobe is low have no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Prescaler modulus pair code |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| load | input | 1 | One-cycle strobe that requests the presented setting |
| div_pulse | output | 1 | One-cycle pulse at the end of each divided period |
| cfg_err | output | 1 | Set by a rejected setting, cleared by a legal load |

## Verification
On every cycle, the assertions check several internal invariants. The prescaler count stays inside its modulus. The swallow and main counters stay within the active setting. The active setting is always legal and changes only at a period boundary. The output pulse is never two cycles wide. Each load drives the error flag to the value its legality calls for.

The exact spacing of the pulses, P*B + A for every modulus pair, can only be shown by the bench's scenarios, because the assertions do not measure it. The same holds for three other behaviours: a load in mid-period leaves the current period whole, a rejected setting leaves the ratio unchanged, and input changes without a strobe are ignored. The bench measures whole periods to show these.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    localparam int A_W        = 6;
    localparam int B_W        = 13;
    localparam int MODE_W     = 2;
    localparam int P_MIN_LOG2 = 3;
    localparam int B_MIN      = 3;
    localparam int P_MAX      = 1 << (P_MIN_LOG2 + (1 << MODE_W) - 1);
    localparam int PC_W       = $clog2(P_MAX + 2);

    typedef enum logic [MODE_W-1:0] {
        PS_8_9   = 2'd0,
        PS_16_17 = 2'd1,
        PS_32_33 = 2'd2,
        PS_64_65 = 2'd3
    } ps_mode_e;

    typedef struct packed {
        ps_mode_e       mode;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } div_cfg_t;

    // Base modulus P for a mode code: doubles with each code step.
    function automatic logic [PC_W-1:0] base_modulus(ps_mode_e m);
        logic [PC_W-1:0] one;
        one = {{(PC_W-1){1'b0}}, 1'b1};
        return one << (P_MIN_LOG2 + int'(m));
    endfunction

    // Legal when B reaches its minimum and B is not below A.
    function automatic logic cfg_legal(logic [A_W-1:0] a, logic [B_W-1:0] b);
        return (b >= B_W'(B_MIN)) && (b >= {{(B_W-A_W){1'b0}}, a});
    endfunction

endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg
    import pswallow_pkg::*;
#(
    parameter div_cfg_t DEF_CFG = '{mode: PS_8_9, a: '0, b: B_W'(B_MIN)}
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t req,
    input  logic     period_end,
    output div_cfg_t active,
    output logic [A_W-1:0] next_a,
    output logic     cfg_err
);

    div_cfg_t pend;
    logic     pend_vld;
    logic     req_ok;
    logic     apply;

    assign req_ok = cfg_legal(req.a, req.b);
    assign apply  = period_end && pend_vld;
    assign next_a = apply ? pend.a : active.a;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= DEF_CFG;
            pend     <= DEF_CFG;
            pend_vld <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            if (apply) begin
                active   <= pend;
                pend_vld <= 1'b0;
            end
            if (load) begin
                if (req_ok) begin
                    pend     <= req;
                    pend_vld <= 1'b1;
                    cfg_err  <= 1'b0;
                end else begin
                    cfg_err  <= 1'b1;
                end
            end
        end
    end

    // R5 / R6: a rejected request raises the flag next cycle
    p_err_on_illegal_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !cfg_legal(req.a, req.b)) |=> cfg_err);

    // R8: a legal request clears the flag next cycle
    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (load && cfg_legal(req.a, req.b)) |=> !cfg_err);

    // R7: the active setting moves only on a period boundary
    p_hold_midperiod_r7: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(active));

    // R4 / R6: only legal settings ever become active
    p_active_legal_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_legal(active.a, active.b));

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
    import pswallow_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ps_mode_e mode,
    input  logic     swallow,
    output logic     pre_tick
);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] limit;

    // Divide by P, or by P+1 while swallowing
    assign limit    = base_modulus(mode) + {{(PC_W-1){1'b0}}, swallow}
                      - {{(PC_W-1){1'b0}}, 1'b1};
    assign pre_tick = (pc == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (pre_tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // R1: count never exceeds the selected modulus
    p_pc_bound_r1: assert property (@(posedge clk) disable iff (rst)
        pc <= base_modulus(mode));

endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters
    import pswallow_pkg::*;
#(
    parameter int DEF_A = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_tick,
    input  logic [A_W-1:0] cur_a,
    input  logic [B_W-1:0] cur_b,
    input  logic [A_W-1:0] next_a,
    output logic           swallow,
    output logic           period_end
);

    logic [B_W-1:0] b_cnt;
    logic [A_W-1:0] a_rem;

    assign swallow    = (a_rem != '0);
    assign period_end = pre_tick && (b_cnt == cur_b - B_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            b_cnt <= '0;
            a_rem <= A_W'(DEF_A);
        end else if (period_end) begin
            b_cnt <= '0;
            a_rem <= next_a;
        end else if (pre_tick) begin
            b_cnt <= b_cnt + 1'b1;
            if (a_rem != '0) a_rem <= a_rem - 1'b1;
        end
    end

    // R2: main count stays below B
    p_bcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        b_cnt < cur_b);

    // R2: swallow budget never exceeds A
    p_arem_bound_r2: assert property (@(posedge clk) disable iff (rst)
        a_rem <= cur_a);

    // R2: all swallowing is finished by the last prescaler period
    p_swallow_done_r2: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (a_rem <= A_W'(1)));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int DEF_MODE = 0,
    parameter int DEF_A    = 0,
    parameter int DEF_B    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    input  logic              load,
    output logic              div_pulse,
    output logic              cfg_err
);

    localparam div_cfg_t DEF_CFG = '{mode: ps_mode_e'(DEF_MODE),
                                     a:    A_W'(DEF_A),
                                     b:    B_W'(DEF_B)};

    div_cfg_t       req;
    div_cfg_t       active;
    logic [A_W-1:0] next_a;
    logic           swallow;
    logic           pre_tick;
    logic           period_end;

    assign req = '{mode: ps_mode_e'(mode_sel), a: a_val, b: b_val};

    pswallow_cfg #(.DEF_CFG(DEF_CFG)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .req        (req),
        .period_end (period_end),
        .active     (active),
        .next_a     (next_a),
        .cfg_err    (cfg_err)
    );

    pswallow_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .mode     (active.mode),
        .swallow  (swallow),
        .pre_tick (pre_tick)
    );

    pswallow_counters #(.DEF_A(DEF_A)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .pre_tick   (pre_tick),
        .cur_a      (active.a),
        .cur_b      (active.b),
        .next_a     (next_a),
        .swallow    (swallow),
        .period_end (period_end)
    );

    assign div_pulse = period_end;

    // R3: the output pulse is a single cycle wide
    p_pulse_narrow_r3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

endmodule

// File: tb/pswallow_divider_tb.sv
`timescale 1ns/1ps
module pswallow_divider_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = '0;
    logic [5:0]  a_val = '0;
    logic [12:0] b_val = 13'd3;
    logic        load = 1'b0;
    logic        div_pulse;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pswallow_divider u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .a_val(a_val),
        .b_val(b_val), .load(load), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  a;
        logic [12:0] b;
        logic [19:0] n;
    } vec_t;

    // Expected N = P*B + A, P = 8 << mode
    localparam vec_t VECS [8] = '{
        '{2'd1, 6'd0,  13'd3,    20'd48},
        '{2'd2, 6'd7,  13'd10,   20'd327},
        '{2'd3, 6'd1,  13'd3,    20'd193},
        '{2'd0, 6'd5,  13'd5,    20'd45},
        '{2'd0, 6'd3,  13'd3,    20'd27},
        '{2'd3, 6'd63, 13'd63,   20'd4095},
        '{2'd0, 6'd63, 13'd1000, 20'd8063},
        '{2'd2, 6'd0,  13'd20,   20'd640}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_to_pulse(input int start, output int n);
        n = start;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    initial begin
        int n;
        int prev_n;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(div_pulse == 1'b0, "R9 pulse in reset", int'(div_pulse), 0);
        chk(cfg_err == 1'b0, "R9 err in reset", int'(cfg_err), 0);
        rst = 1'b0;
        count_to_pulse(1, n);
        chk(n == 24, "R9 first period", n, 24);
        prev_n = 24;

        // R1 / R2 / R4 / R7 table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
            repeat (2) @(negedge clk);
            mode_sel = VECS[i].mode;
            a_val    = VECS[i].a;
            b_val    = VECS[i].b;
            load     = 1'b1;
            @(negedge clk);
            load     = 1'b0;
            chk(cfg_err == 1'b0, "R4 legal accepted", int'(cfg_err), 0);
            count_to_pulse(4, n);
            chk(n == prev_n, "R7 current period kept", n, prev_n);
            count_to_pulse(0, n);
            chk(n == int'(VECS[i].n), "R1 R2 new period", n, int'(VECS[i].n));
            prev_n = int'(VECS[i].n);
        end

        // R10: input changes without strobe are ignored
        @(negedge clk);
        mode_sel = 2'd3; a_val = 6'd9; b_val = 13'd77;
        count_to_pulse(1, n);
        chk(n == prev_n, "R10 no strobe current", n, prev_n);
        count_to_pulse(0, n);
        chk(n == prev_n, "R10 no strobe next", n, prev_n);

        // R5: B below minimum rejected
        @(negedge clk);
        mode_sel = 2'd0; a_val = 6'd0; b_val = 13'd2; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(cfg_err == 1'b1, "R5 err raised", int'(cfg_err), 1);
        count_to_pulse(2, n);
        chk(n == prev_n, "R5 current period", n, prev_n);
        count_to_pulse(0, n);
        chk(n == prev_n, "R5 ratio held", n, prev_n);

        // R8 then R6: legal load clears flag, later illegal keeps pending legal
        @(negedge clk);
        mode_sel = 2'd0; a_val = 6'd2; b_val = 13'd4; load = 1'b1;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R8 err cleared", int'(cfg_err), 0);
        a_val = 6'd10; b_val = 13'd5;
        @(negedge clk);
        load = 1'b0;
        chk(cfg_err == 1'b1, "R6 err raised", int'(cfg_err), 1);
        count_to_pulse(3, n);
        chk(n == prev_n, "R6 current period", n, prev_n);
        count_to_pulse(0, n);
        chk(n == 34, "R6 earlier legal kept", n, 34);
        chk(cfg_err == 1'b1, "R8 err sticky", int'(cfg_err), 1);

        finish_run();
    end

endmodule